// File: doc/BRIEF.md
# Secondary Interrupt Controller with Pass-Through Lanes

This block gathers 32 level-sensitive interrupt sources in front of a primary vectored interrupt controller. Each source is captured every clock. It is merged with a software-raised request bit, gated by a per-source mask, and folded into one combined request line toward the primary controller. Vectoring, priority and nesting are left to the primary controller.

A band of sources (default 21 through 30) can instead be steered straight onto the primary input with the same number. An enabled lane mirrors the source's effective level and ignores the mask. A lane whose enable is off keeps whatever value it last drove. Software reaches the block through a word-addressed register window of 4 KB with separate read and write strobes. The word index is the byte address shifted right by two.

The block has no state machine. It is a set of registers with next-state logic. All outputs are registered and change one clock after the input sample or strobe that causes the change.

Top module: `sic_top`

## Requirements
- R1: After reset the level, mask, software-request and pass-through registers are zero, `prim_out` is all zero, `rd_data` is zero and `bad_acc` is low.
- R2: The effective level is the sampled inputs ORed with the software-request bits. A read at word index 1 returns this effective level, with the inputs taken as sampled at the previous clock edge.
- R3: A write to word index 2 sets the mask bits where `wr_data` is 1. A write to word index 3 clears them where `wr_data` is 1. A read at word index 2 returns the mask.
- R4: A read at word index 0 returns the status, which is the effective level ANDed with the mask.
- R5: A write to word index 4 sets software-request bits where `wr_data` is 1. A write to word index 5 clears them where `wr_data` is 1.
- R6: `prim_out[COMB_LINE]` (default bit 31) is high exactly when the status is non-zero. It updates one clock after the input or write that changes the status. Bits that are neither the combined line nor a pass-through lane stay low.
- R7: A write to word index 8 ORs `wr_data` into the pass-through enable register, and only bits 21..30 can become set. A write to word index 9 clears the enable bits where `wr_data` is 1. A read at word index 8 returns the enable register.
- R8: For each lane n in 21..30 whose enable is set, `prim_out[n]` equals bit n of the effective level, one clock later, whatever the mask holds.
- R9: For each lane n in 21..30 whose enable is clear, `prim_out[n]` holds its previous value.
- R10: A read of any index other than 0, 1, 2 or 8 returns zero. A write to any index other than 2, 3, 4, 5, 8 or 9 changes no state. Either access raises `bad_acc` for one cycle, in the cycle after the strobe. Address bits 1:0 are ignored.
- R11: `rd_data` is loaded in the cycle after `rd_en` with state from before any write in the same cycle, and holds between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Byte address inside the 4 KB window |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| bad_acc | output | 1 | One-cycle flag for an access to an undefined index |
| irq_in | input | 32 | Level-sensitive interrupt sources |
| prim_out | output | 32 | Lines toward the primary controller |

## Verification
The assertions assume that `irq_in`, the strobes, `addr` and `wr_data` are stable around each rising edge. They also assume that the combined line parameter lies outside the pass-through band. The bench changes every input just after a falling edge and keeps the default parameters, so both assumptions hold. Its pseudo-random phase mixes reads and writes to every index in 0..15, including reads and writes in the same cycle and addresses whose low two bits are non-zero, because the design defines a result for all of these.

// File: rtl/sic_pkg.sv
package sic_pkg;
    localparam int ADDR_W = 12;
    localparam int IDX_W  = ADDR_W - 2;

    localparam logic [IDX_W-1:0] IX_STAT = IDX_W'(0);
    localparam logic [IDX_W-1:0] IX_RAW  = IDX_W'(1);
    localparam logic [IDX_W-1:0] IX_MSET = IDX_W'(2);
    localparam logic [IDX_W-1:0] IX_MCLR = IDX_W'(3);
    localparam logic [IDX_W-1:0] IX_SSET = IDX_W'(4);
    localparam logic [IDX_W-1:0] IX_SCLR = IDX_W'(5);
    localparam logic [IDX_W-1:0] IX_PSET = IDX_W'(8);
    localparam logic [IDX_W-1:0] IX_PCLR = IDX_W'(9);
endpackage

// File: rtl/sic_regs.sv
module sic_regs
    import sic_pkg::*;
#(
    parameter int N     = 32,
    parameter int PT_LO = 21,
    parameter int PT_HI = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N-1:0]      wdata,
    input  logic [N-1:0]      irq_in,
    output logic [N-1:0]      rdata_q,
    output logic              bad_q,
    output logic [N-1:0]      eff_q,
    output logic [N-1:0]      mask_q,
    output logic [N-1:0]      pte_q,
    output logic [N-1:0]      eff_d,
    output logic [N-1:0]      mask_d,
    output logic [N-1:0]      pte_d
);
    logic [IDX_W-1:0] idx;
    logic [1:0]       unused_lo;
    logic [N-1:0]     lvl_q, soft_q, soft_d, pt_msk, rd_val;
    logic             wr_bad, rd_bad;

    assign idx       = addr[ADDR_W-1:2];
    assign unused_lo = addr[1:0];

    for (genvar k = 0; k < N; k++) begin : g_ptmsk
        assign pt_msk[k] = (k >= PT_LO) && (k <= PT_HI);
    end

    assign eff_q = lvl_q | soft_q;

    always_comb begin
        soft_d = soft_q;
        mask_d = mask_q;
        pte_d  = pte_q;
        wr_bad = 1'b0;
        if (wr_en) begin
            unique case (idx)
                IX_MSET: mask_d = mask_q | wdata;
                IX_MCLR: mask_d = mask_q & ~wdata;
                IX_SSET: soft_d = soft_q | wdata;
                IX_SCLR: soft_d = soft_q & ~wdata;
                IX_PSET: pte_d  = pte_q | (wdata & pt_msk);
                IX_PCLR: pte_d  = pte_q & ~wdata;
                default: wr_bad = 1'b1;
            endcase
        end
    end

    always_comb begin
        rd_bad = 1'b0;
        unique case (idx)
            IX_STAT: rd_val = eff_q & mask_q;
            IX_RAW:  rd_val = eff_q;
            IX_MSET: rd_val = mask_q;
            IX_PSET: rd_val = pte_q;
            default: begin
                rd_val = '0;
                rd_bad = 1'b1;
            end
        endcase
    end

    assign eff_d = irq_in | soft_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q   <= '0;
            soft_q  <= '0;
            mask_q  <= '0;
            pte_q   <= '0;
            rdata_q <= '0;
            bad_q   <= 1'b0;
        end else begin
            lvl_q  <= irq_in;
            soft_q <= soft_d;
            mask_q <= mask_d;
            pte_q  <= pte_d;
            if (rd_en) rdata_q <= rd_val;
            bad_q  <= (rd_en && rd_bad) || (wr_en && wr_bad);
        end
    end

    // R3
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == IX_MCLR) |=> ((mask_q & $past(wdata)) == '0));

    // R5
    soft_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == IX_SSET) |=> ((eff_q & $past(wdata)) == $past(wdata)));

    // R7
    pte_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == IX_PSET) |=> ((pte_q & ~pt_msk) == ($past(pte_q) & ~pt_msk)));

    // R10
    bad_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && idx != IX_STAT && idx != IX_RAW && idx != IX_MSET && idx != IX_PSET)
        |=> (bad_q && rdata_q == '0));
endmodule

// File: rtl/sic_route.sv
module sic_route #(
    parameter int N         = 32,
    parameter int PT_LO     = 21,
    parameter int PT_HI     = 30,
    parameter int COMB_LINE = 31
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] eff_d,
    input  logic [N-1:0] mask_d,
    input  logic [N-1:0] pte_d,
    input  logic [N-1:0] eff_q,
    input  logic [N-1:0] mask_q,
    input  logic [N-1:0] pte_q,
    output logic [N-1:0] out_q
);
    logic [N-1:0] out_d;
    logic         comb_d;

    assign comb_d = |(eff_d & mask_d);

    for (genvar k = 0; k < N; k++) begin : g_line
        if (k == COMB_LINE) begin : g_comb
            assign out_d[k] = comb_d;
            // R6
            comb_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
                out_q[k] == (|(eff_q & mask_q)));
        end else if (k >= PT_LO && k <= PT_HI) begin : g_pass
            assign out_d[k] = pte_d[k] ? eff_d[k] : out_q[k];
            // R8
            pass_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
                pte_q[k] |-> (out_q[k] == eff_q[k]));
            // R9
            pass_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !pte_q[k] |-> $stable(out_q[k]));
        end else begin : g_idle
            assign out_d[k] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end
endmodule

// File: rtl/sic_top.sv
module sic_top
    import sic_pkg::*;
#(
    parameter int N         = 32,
    parameter int PT_LO     = 21,
    parameter int PT_HI     = 30,
    parameter int COMB_LINE = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N-1:0]      wr_data,
    output logic [N-1:0]      rd_data,
    output logic              bad_acc,
    input  logic [N-1:0]      irq_in,
    output logic [N-1:0]      prim_out
);
    logic [N-1:0] eff_q, mask_q, pte_q, eff_d, mask_d, pte_d;

    sic_regs #(.N(N), .PT_LO(PT_LO), .PT_HI(PT_HI)) i_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .addr   (addr),
        .wdata  (wr_data),
        .irq_in (irq_in),
        .rdata_q(rd_data),
        .bad_q  (bad_acc),
        .eff_q  (eff_q),
        .mask_q (mask_q),
        .pte_q  (pte_q),
        .eff_d  (eff_d),
        .mask_d (mask_d),
        .pte_d  (pte_d)
    );

    sic_route #(.N(N), .PT_LO(PT_LO), .PT_HI(PT_HI), .COMB_LINE(COMB_LINE)) i_route (
        .clk   (clk),
        .rst_n (rst_n),
        .eff_d (eff_d),
        .mask_d(mask_d),
        .pte_d (pte_d),
        .eff_q (eff_q),
        .mask_q(mask_q),
        .pte_q (pte_q),
        .out_q (prim_out)
    );

    // R11
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

// File: tb/test_sic_top.sv
module test_sic_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] irq_in = '0;
    logic [31:0] rd_data, prim_out;
    logic        bad_acc;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference model state
    logic [31:0] m_lvl = '0, m_soft = '0, m_mask = '0, m_pte = '0, m_out = '0, m_rd = '0;
    logic        m_bad = 1'b0;
    string       m_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    sic_top i_sic_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .bad_acc(bad_acc),
        .irq_in(irq_in), .prim_out(prim_out)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_lvl = '0; m_soft = '0; m_mask = '0; m_pte = '0;
            m_out = '0; m_rd = '0; m_bad = 1'b0; m_tag = "R1";
        end else begin
            int ix;
            logic [31:0] eff, nsoft, nmask, npte, neff;
            bit rbad, wbad;
            ix = int'(addr[11:2]);
            eff = m_lvl | m_soft;
            nsoft = m_soft; nmask = m_mask; npte = m_pte;
            rbad = 0; wbad = 0;
            if (rd_en) begin
                case (ix)
                    0: begin m_rd = eff & m_mask; m_tag = "R4"; end
                    1: begin m_rd = eff;          m_tag = "R2"; end
                    2: begin m_rd = m_mask;       m_tag = "R3"; end
                    8: begin m_rd = m_pte;        m_tag = "R7"; end
                    default: begin m_rd = 0; rbad = 1; m_tag = "R10"; end
                endcase
            end
            if (wr_en) begin
                case (ix)
                    2: nmask = m_mask | wr_data;
                    3: nmask = m_mask & ~wr_data;
                    4: nsoft = m_soft | wr_data;
                    5: nsoft = m_soft & ~wr_data;
                    8: for (int b = 21; b <= 30; b++) if (wr_data[b]) npte[b] = 1'b1;
                    9: npte = m_pte & ~wr_data;
                    default: wbad = 1;
                endcase
            end
            m_bad = rbad || wbad;
            m_lvl = irq_in; m_soft = nsoft; m_mask = nmask; m_pte = npte;
            neff = m_lvl | m_soft;
            m_out[31] = ((neff & m_mask) != 0);
            for (int b = 21; b <= 30; b++) if (m_pte[b]) m_out[b] = neff[b];
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        chk("R6", {prim_out[31], 10'b0, prim_out[20:0]}, {m_out[31], 10'b0, m_out[20:0]});
        chk("R8/R9", {22'b0, prim_out[30:21]}, {22'b0, m_out[30:21]});
        chk(m_tag, rd_data, m_rd);
        chk("R10", {31'b0, bad_acc}, {31'b0, m_bad});
    endtask

    task automatic wr(int ix, logic [31:0] d);
        addr = 12'(ix << 2); wr_data = d; wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd(int ix);
        addr = 12'(ix << 2); rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
        tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] lf;
        lf = 32'h1234_5678;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", prim_out, 32'h0);
        chk("R1", rd_data, 32'h0);
        chk("R1", {31'b0, bad_acc}, 32'h0);
        rst_n = 1'b1;
        tick();
        rd(0); rd(1); rd(2); rd(8);
        // R2: level follows inputs
        irq_in = 32'h0000_00F0; tick(); rd(1);
        // R3/R4/R6: mask and status
        wr(2, 32'h0000_0030); rd(2); rd(0);
        irq_in = 32'h0; tick(); tick();
        // R5: software requests
        wr(4, 32'h0000_0010); rd(1); rd(0);
        wr(5, 32'h0000_0010); rd(0);
        wr(3, 32'hFFFF_FFFF); rd(2);
        // R7: enable band
        wr(8, 32'hFFFF_FFFF); rd(8);
        // R8: mirroring ignores mask
        irq_in = 32'h2AA0_0000; tick(); tick();
        irq_in = 32'h5540_0000; tick(); tick();
        wr(4, 32'h0020_0000); tick();
        wr(5, 32'h0020_0000); tick();
        // R9: disabled lanes hold
        wr(9, 32'h5540_0000); rd(8);
        irq_in = 32'h0; tick(); tick();
        irq_in = 32'h7FE0_0000; tick(); tick();
        // R10: undefined indices, low address bits ignored
        rd(7); rd(12);
        wr(6, 32'hFFFF_FFFF); rd(2); rd(1);
        addr = 12'h023; rd_en = 1'b1; tick(); rd_en = 1'b0; tick();
        // R11: read alongside a write returns the old state
        addr = 12'h008; wr_data = 32'h0000_0F00; wr_en = 1'b1; rd_en = 1'b1;
        tick(); wr_en = 1'b0; rd_en = 1'b0; tick(); rd(2);
        // mixed pseudo-random traffic
        for (int i = 0; i < 400; i++) begin
            lf = lf[0] ? ((lf >> 1) ^ 32'hA300_0000) : (lf >> 1);
            irq_in = (lf[3:0] < 4'd5) ? {lf[15:0], lf[31:16]} : irq_in;
            lf = lf[0] ? ((lf >> 1) ^ 32'hA300_0000) : (lf >> 1);
            wr_en = lf[5] & lf[6];
            rd_en = lf[7] | lf[8];
            addr = {6'b0, lf[12:9], lf[14:13]};
            wr_data = {lf[7:0], lf[31:8]};
            tick();
        end
        wr_en = 1'b0; rd_en = 1'b0;
        tick(); tick();
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule